// File: doc/BRIEF.md
# EDO Read-Port Output-Enable Controller

This block governs the data-output enable and the output data latch of an extended-data-out DRAM read port. Once per clock it samples the row strobe, a set of column strobes (one per data lane), the transfer/output-enable control and the write-enable control. From these it decides when read data starts being driven and for how long it is held after the column strobe rises. It also decides when the port returns to high impedance. Each data lane has its own latch. A lane loads a new word from the array-side data input on each falling edge of its column strobe during a read. This supports plain reads, page-mode reads and read-modify-write cycles.

A refresh decoder outside the block supplies the kind of refresh cycle in progress. CAS-before-RAS refreshes force the output to high impedance. A RAS-only refresh does the same unless a column strobe and the output-enable control are both low. During a hidden refresh the word from the preceding read stays on the port unchanged. The latch width and the number of column strobes are parameters, and the data width is split evenly across the lanes.

Top module: `edo_oe_ctrl`

## Requirements
- R1: When reset is asserted, `oe` is 0 and `dout` is all zeros.
- R2: Once `oe` is 1, it stays 1 on the next clock while all column strobes are high, provided `ras_n`, `trg_n` are low, `we_n` is high and `rfsh_kind` is 0 (no refresh) or 3 (hidden).
- R3: A sample with `we_n` low, or with `trg_n` high, or with every column strobe and `ras_n` high, makes `oe` 0 on the next clock.
- R4: Lane i of `dout` is bits [i*LW +: LW], where LW = DATA_W/NUM_CAS. On an accepted read, the lane loads the same bits of `din` when `cas_n[i]` falls, or when `cas_n[i]` is low while `oe` is still 0. Otherwise the lane keeps its value.
- R5: An accepted read sets `oe` to 1 on the next clock. A read is accepted when `rfsh_kind` is 0, `ras_n` and `trg_n` are low, `we_n` is high and at least one column strobe is low.
- R6: While `rfsh_kind` is 1 (any CAS-before-RAS refresh), `oe` is 0 on the next clock, whatever `trg_n` is.
- R7: While `rfsh_kind` is 2 (RAS-only refresh), `oe` is 0 on the next clock unless some column strobe is low and `trg_n` is low. In that case the cycle behaves as a normal read.
- R8: While `rfsh_kind` is 3 (hidden refresh), no lane loads new data and `oe` cannot rise. The word and enable from the preceding read are kept until one of the R3 conditions releases them.
- R9: In page mode, each new column strobe fall in a read replaces the lane data while `oe` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | NUM_CAS | Column strobes, one per lane, active low |
| trg_n | input | 1 | Output-enable / transfer control, active low |
| we_n | input | 1 | Write enable, active low |
| rfsh_kind | input | 2 | Refresh kind: 0 none, 1 CAS-before-RAS, 2 RAS-only, 3 hidden |
| din | input | DATA_W | Read data from the array |
| dout | output | DATA_W | Latched output data |
| oe | output | 1 | Output driven (1) or high impedance (0) |

## Verification
The bench builds the block with DATA_W = 16 and NUM_CAS = 2, giving two 8-bit lanes with independent strobes. With two lanes, a fall on one strobe while the other is already low is reachable, so the bench can check that only the falling lane reloads. It can also check that a strobe held low through `oe` rising still captures. Random strobe walks with weighted refresh kinds cover the priority between refresh forcing, release and enabling. Directed sequences pin down page-mode reads, read-modify-write release, and hidden refresh with the row strobe cycling.

// File: rtl/edo_pkg.sv
package edo_pkg;

   typedef enum logic [1:0] {
      RF_NONE    = 2'd0,
      RF_CBR     = 2'd1,
      RF_RASONLY = 2'd2,
      RF_HIDDEN  = 2'd3
   } rfsh_kind_e;

endpackage

// File: rtl/edo_cas_edge.sv
module edo_cas_edge #(
   parameter int NUM_CAS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CAS-1:0] cas_n,
   output logic [NUM_CAS-1:0] fall,
   output logic               any_low,
   output logic               all_high
);

   logic [NUM_CAS-1:0] prev_q;

   for (genvar g = 0; g < NUM_CAS; g++) begin : g_strobe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[g] <= 1'b1;
         else        prev_q[g] <= cas_n[g];
      end
      assign fall[g] = prev_q[g] & ~cas_n[g];
   end

   assign any_low  = ~(&cas_n);
   assign all_high = &cas_n;

endmodule

// File: rtl/edo_oe_gate.sv
module edo_oe_gate
   import edo_pkg::*;
(
   input  logic       ras_n,
   input  logic       trg_n,
   input  logic       we_n,
   input  rfsh_kind_e kind,
   input  logic       cas_any_low,
   input  logic       cas_all_high,
   input  logic       oe_q,
   output logic       accept,
   output logic       oe_d
);

   logic release_c;
   logic force_hiz;
   logic read_ok;

   always_comb begin
      release_c = ~we_n | trg_n | (cas_all_high & ras_n);
      unique case (kind)
         RF_CBR:     force_hiz = 1'b1;
         RF_RASONLY: force_hiz = ~(cas_any_low & ~trg_n);
         default:    force_hiz = 1'b0;
      endcase
      read_ok = ~ras_n & ~trg_n & we_n & cas_any_low;
      accept  = read_ok & ~release_c & ~force_hiz & (kind != RF_HIDDEN);
      if (release_c || force_hiz) oe_d = 1'b0;
      else if (accept)            oe_d = 1'b1;
      else                        oe_d = oe_q;
   end

endmodule

// File: rtl/edo_lane_latch.sv
module edo_lane_latch #(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] d,
   output logic [LW-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

endmodule

// File: rtl/edo_oe_ctrl.sv
module edo_oe_ctrl
   import edo_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NUM_CAS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ras_n,
   input  logic [NUM_CAS-1:0] cas_n,
   input  logic               trg_n,
   input  logic               we_n,
   input  logic [1:0]         rfsh_kind,
   input  logic [DATA_W-1:0]  din,
   output logic [DATA_W-1:0]  dout,
   output logic               oe
);

   localparam int LW = DATA_W / NUM_CAS;

   if (NUM_CAS < 1 || DATA_W < 1 || (DATA_W % NUM_CAS) != 0) begin : g_bad_cfg
      $error("edo_oe_ctrl: DATA_W must split evenly over NUM_CAS >= 1");
   end

   rfsh_kind_e         kind;
   logic [NUM_CAS-1:0] fall;
   logic               any_low, all_high;
   logic               accept, oe_d, oe_q;

   assign kind = rfsh_kind_e'(rfsh_kind);

   edo_cas_edge #(.NUM_CAS(NUM_CAS)) u_edge (
      .clk(clk), .rst_n(rst_n), .cas_n(cas_n),
      .fall(fall), .any_low(any_low), .all_high(all_high)
   );

   edo_oe_gate u_gate (
      .ras_n(ras_n), .trg_n(trg_n), .we_n(we_n), .kind(kind),
      .cas_any_low(any_low), .cas_all_high(all_high),
      .oe_q(oe_q), .accept(accept), .oe_d(oe_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= oe_d;
   end

   for (genvar l = 0; l < NUM_CAS; l++) begin : g_lane
      logic lane_load;
      assign lane_load = accept & ~cas_n[l] & (fall[l] | ~oe_q);
      edo_lane_latch #(.LW(LW)) u_lat (
         .clk(clk), .rst_n(rst_n), .load(lane_load),
         .d(din[l*LW +: LW]), .q(dout[l*LW +: LW])
      );
   end

   assign oe = oe_q;

   AST_RESET_HIZ: assert property (@(posedge clk) !rst_n |=> !oe); // R1
   AST_HOLD_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && (&cas_n) && !ras_n && !trg_n && we_n &&
       (rfsh_kind == 2'd0 || rfsh_kind == 2'd3)) |=> oe); // R2
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || trg_n || ((&cas_n) && ras_n)) |=> !oe); // R3
   AST_ENABLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_kind == 2'd0 && !ras_n && !trg_n && we_n && !(&cas_n)) |=> oe); // R5
   AST_CBR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_kind == 2'd1) |=> !oe); // R6
   AST_RASONLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_kind == 2'd2 && ((&cas_n) || trg_n)) |=> !oe); // R7
   AST_HIDDEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_kind == 2'd3) |=> ($stable(dout) && !$rose(oe))); // R8

endmodule

// File: tb/edo_oe_ctrl_test.sv
module edo_oe_ctrl_test;

   localparam int DW = 16;
   localparam int NC = 2;
   localparam int LW = DW / NC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1;
   logic [NC-1:0] cas_n = '1;
   logic          trg_n = 1'b1;
   logic          we_n = 1'b1;
   logic [1:0]    rfsh_kind = 2'd0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          oe;

   int total = 0;
   int bad = 0;

   logic          m_oe = 1'b0;
   logic [DW-1:0] m_dout = '0;
   logic [NC-1:0] m_prev = '1;
   string         m_tag = "R1";

   always #4 clk = ~clk;

   edo_oe_ctrl #(.DATA_W(DW), .NUM_CAS(NC)) uut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
      .trg_n(trg_n), .we_n(we_n), .rfsh_kind(rfsh_kind),
      .din(din), .dout(dout), .oe(oe)
   );

   function automatic string reason_of(logic r, logic [NC-1:0] c, logic t,
                                       logic w, logic [1:0] k);
      if (k == 2'd1)                        return "R6";
      if (k == 2'd2 && ((&c) || t))         return "R7";
      if (!w || t || ((&c) && r))           return "R3";
      if (k == 2'd3)                        return "R8";
      if (!r && !(&c))                      return "R5/R4";
      return "R2";
   endfunction

   // advance the reference by one clock using the currently applied inputs
   task automatic model_step();
      logic rel, frc, acc, old_oe;
      old_oe = m_oe;
      rel = !we_n || trg_n || ((&cas_n) && ras_n);
      frc = (rfsh_kind == 2'd1) || (rfsh_kind == 2'd2 && ((&cas_n) || trg_n));
      acc = !ras_n && !trg_n && we_n && !(&cas_n) && !rel && !frc && rfsh_kind != 2'd3;
      m_tag = reason_of(ras_n, cas_n, trg_n, we_n, rfsh_kind);
      if (rel || frc) m_oe = 1'b0;
      else if (acc)   m_oe = 1'b1;
      for (int i = 0; i < NC; i++) begin
         if (acc && !cas_n[i] && (m_prev[i] || !old_oe)) begin
            m_dout[i*LW +: LW] = din[i*LW +: LW];
            if (old_oe && m_tag == "R5/R4") m_tag = "R9/R4";
         end
      end
      m_prev = cas_n;
   endtask

   task automatic check_outputs(string tag);
      total++;
      if (oe !== m_oe) begin
         bad++;
         $display("FAIL %s oe actual=%0b expected=%0b t=%0t", tag, oe, m_oe, $time);
      end
      total++;
      if (dout !== m_dout) begin
         bad++;
         $display("FAIL %s dout actual=%h expected=%h t=%0t", tag, dout, m_dout, $time);
      end
   endtask

   // apply inputs at a falling edge, then check one clock later
   task automatic cyc(logic r, logic [NC-1:0] c, logic t, logic w, logic [1:0] k,
                      logic [DW-1:0] d);
      ras_n = r; cas_n = c; trg_n = t; we_n = w; rfsh_kind = k; din = d;
      model_step();
      @(negedge clk);
      check_outputs(m_tag);
   endtask

   initial begin
      process::self().srandom(32'h5EED_0A11);
      #2;
      check_outputs("R1");
      repeat (3) @(negedge clk);
      check_outputs("R1");
      rst_n = 1'b1;
      @(negedge clk);

      // R5 R4: plain read, both strobes fall together
      cyc(1'b0, 2'b11, 1'b0, 1'b1, 2'd0, 16'h1111);
      cyc(1'b0, 2'b00, 1'b0, 1'b1, 2'd0, 16'hA55A);
      // R2: strobes rise, output held
      cyc(1'b0, 2'b11, 1'b0, 1'b1, 2'd0, 16'h0000);
      cyc(1'b0, 2'b11, 1'b0, 1'b1, 2'd0, 16'hFFFF);
      // R9 R4: page mode, lane 0 only, then lane 1 only
      cyc(1'b0, 2'b10, 1'b0, 1'b1, 2'd0, 16'h3C77);
      cyc(1'b0, 2'b00, 1'b0, 1'b1, 2'd0, 16'h9E00);
      // R8: hidden refresh, RAS cycles with strobes low
      cyc(1'b1, 2'b00, 1'b0, 1'b1, 2'd3, 16'h1234);
      cyc(1'b0, 2'b00, 1'b0, 1'b1, 2'd3, 16'h5678);
      cyc(1'b1, 2'b00, 1'b0, 1'b1, 2'd3, 16'h9ABC);
      // R3: read-modify-write, WE low releases
      cyc(1'b0, 2'b00, 1'b0, 1'b0, 2'd0, 16'h4444);
      // R3: both strobes and RAS high release
      cyc(1'b0, 2'b00, 1'b0, 1'b1, 2'd0, 16'h7070);
      cyc(1'b1, 2'b11, 1'b0, 1'b1, 2'd0, 16'h0101);
      // R6: CBR with TRG low
      cyc(1'b0, 2'b01, 1'b0, 1'b1, 2'd1, 16'h2222);
      cyc(1'b0, 2'b00, 1'b0, 1'b1, 2'd1, 16'h2323);
      // R7: RAS-only without strobe, then with strobe and TRG low
      cyc(1'b0, 2'b11, 1'b0, 1'b1, 2'd2, 16'h3333);
      cyc(1'b0, 2'b01, 1'b0, 1'b1, 2'd2, 16'hBEEF);
      // R3: TRG high releases
      cyc(1'b0, 2'b01, 1'b1, 1'b1, 2'd0, 16'h5555);

      // constrained random walk
      for (int n = 0; n < 4000; n++) begin
         logic          r, t, w;
         logic [NC-1:0] c;
         logic [1:0]    k;
         int            pk;
         r = ($urandom_range(0, 5) == 0) ? ~ras_n : ras_n;
         c = cas_n;
         for (int i = 0; i < NC; i++)
            if ($urandom_range(0, 2) == 0) c[i] = ~c[i];
         t = ($urandom_range(0, 9) == 0) ? ~trg_n : trg_n;
         if (t && $urandom_range(0, 1) == 0) t = 1'b0;
         w = ($urandom_range(0, 11) == 0) ? 1'b0 : 1'b1;
         pk = $urandom_range(0, 9);
         k = (pk < 6) ? 2'd0 : (pk == 6) ? 2'd1 : (pk == 7) ? 2'd2 : 2'd3;
         cyc(r, c, t, w, k, 16'($urandom));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule